// File: doc/BRIEF.md
# Indirectly Addressed GPIO Port

This block is an 8-pin general-purpose I/O port behind a small register bus. Four byte registers sit at consecutive bus offsets: a sub-register selector, a window register, the sampled pin inputs and the output data latch. Configuration is reached through the window. Software first writes a sub-register index into the selector. Later reads and writes at the window offset then go to the sub-register that index names. Index 01h reaches the direction bits and index 02h reaches the alternate-function bits.

Each pin drives a tri-state pad through three signals: output value, output enable and input value. A pin whose direction bit is 0 drives its output data bit. A pin whose direction bit is 1 releases the pad. A pin whose alternate-function bit is set takes its enable and its value from the external function inputs and ignores the direction setting. The pad inputs of every pin pass through a synchronizer and land in a read-only input register once per clock.

Top module: `ind_gpio_port`

## Requirements
- R1: While `rst` is high and after it is released, the selector and output data latch hold 00h, every direction bit holds 1, every alternate-function bit holds 0, `pad_oe` is 00h and `rdata` is 00h.
- R2: The bus offsets are 0 for the selector, 1 for the window, 2 for the input register and 3 for the output data latch. The selector and the latch read back the full byte last written to them.
- R3: With selector value 01h, a window write sets the direction bits and a window read returns them.
- R4: With selector value 02h, a window write sets the alternate-function bits and a window read returns them.
- R5: With any selector value other than 01h or 02h, a window write changes no sub-register and a window read returns 00h.
- R6: A pin with alternate bit 0 and direction bit 0 has `pad_oe` = 1. `pad_out` for any pin with alternate bit 0 equals its output data bit.
- R7: A pin with alternate bit 0 and direction bit 1 has `pad_oe` = 0.
- R8: A pin with alternate bit 1 has `pad_oe` = `alt_oe` and `pad_out` = `alt_out` for that pin, whatever its direction bit holds.
- R9: The input register holds `pad_in` as sampled three rising edges earlier (two synchronizer stages and the register). Writes to offset 2 have no effect.
- R10: A read with `cs`=1 and `we`=0 loads `rdata` at that rising edge. At every other edge `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Bus select |
| we | input | 1 | Write strobe (1 = write, 0 = read) |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables (1 = drive) |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |

## Verification
The bench builds the port with its defaults: eight pins, so selector and data are full bytes, and two synchronizer stages. Full-byte selectors let it try unmapped indices such as 00h, 03h and FFh next to the two live ones. Two stages fix the input latency at three edges, and the bench tests that boundary by reading the input register on the third and fourth edges after a pad change. Mixed masks for direction, alternate and function inputs put every mux case on some pin within a single check.

// File: rtl/ind_gpio_pkg.sv
package ind_gpio_pkg;
  // Bus offsets of the four byte registers
  localparam int unsigned OFS_SEL = 0;
  localparam int unsigned OFS_WIN = 1;
  localparam int unsigned OFS_IN  = 2;
  localparam int unsigned OFS_OUT = 3;
  // Sub-register indices reached through the window
  localparam int unsigned IDX_DIR = 1;
  localparam int unsigned IDX_ALT = 2;
endpackage

// File: rtl/ind_gpio_sync.sv
module ind_gpio_sync #(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] d,
  output logic [PIN_W-1:0] q
);
  logic [PIN_W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[s] <= '0;
        else     st[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[s] <= '0;
        else     st[s] <= st[s-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ind_gpio_regs.sv
module ind_gpio_regs
  import ind_gpio_pkg::*;
#(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  input  logic [PIN_W-1:0]  in_val,
  output logic [PIN_W-1:0]  rdata,
  output logic [PIN_W-1:0]  idx_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  alt_q,
  output logic [PIN_W-1:0]  odr_q
);
  localparam logic [PIN_W-1:0] SEL_DIR = PIN_W'(IDX_DIR);
  localparam logic [PIN_W-1:0] SEL_ALT = PIN_W'(IDX_ALT);

  logic wr_en, rd_en;
  logic hit_sel, hit_win, hit_in, hit_out;
  logic [PIN_W-1:0] win_val, rd_mux;

  assign wr_en   = cs && we;
  assign rd_en   = cs && !we;
  assign hit_sel = (addr == ADDR_W'(OFS_SEL));
  assign hit_win = (addr == ADDR_W'(OFS_WIN));
  assign hit_in  = (addr == ADDR_W'(OFS_IN));
  assign hit_out = (addr == ADDR_W'(OFS_OUT));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      dir_q <= '1;
      alt_q <= '0;
      odr_q <= '0;
    end else if (wr_en) begin
      if (hit_sel) idx_q <= wdata;
      if (hit_out) odr_q <= wdata;
      if (hit_win && idx_q == SEL_DIR) dir_q <= wdata;
      if (hit_win && idx_q == SEL_ALT) alt_q <= wdata;
    end
  end

  always_comb begin
    unique case (idx_q)
      SEL_DIR: win_val = dir_q;
      SEL_ALT: win_val = alt_q;
      default: win_val = '0;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sel) rd_mux = idx_q;
    if (hit_win) rd_mux = win_val;
    if (hit_in)  rd_mux = in_val;
    if (hit_out) rd_mux = odr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ind_gpio_padmux.sv
module ind_gpio_padmux #(
  parameter int unsigned PIN_W = 8
) (
  input  logic [PIN_W-1:0] dir,
  input  logic [PIN_W-1:0] alt,
  input  logic [PIN_W-1:0] odr,
  input  logic [PIN_W-1:0] alt_out,
  input  logic [PIN_W-1:0] alt_oe,
  output logic [PIN_W-1:0] pad_out,
  output logic [PIN_W-1:0] pad_oe
);
  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    always_comb begin
      if (alt[p]) begin
        pad_out[p] = alt_out[p];
        pad_oe[p]  = alt_oe[p];
      end else begin
        pad_out[p] = odr[p];
        pad_oe[p]  = !dir[p];
      end
    end
  end
endmodule

// File: rtl/ind_gpio_port.sv
module ind_gpio_port #(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  output logic [PIN_W-1:0]  rdata,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe,
  input  logic [PIN_W-1:0]  alt_out,
  input  logic [PIN_W-1:0]  alt_oe
);
  logic [PIN_W-1:0] sync_q, in_q;
  logic [PIN_W-1:0] idx_q, dir_q, alt_q, odr_q;

  ind_gpio_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= sync_q;
  end

  ind_gpio_regs #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .cs     (cs),
    .we     (we),
    .addr   (addr),
    .wdata  (wdata),
    .in_val (in_q),
    .rdata  (rdata),
    .idx_q  (idx_q),
    .dir_q  (dir_q),
    .alt_q  (alt_q),
    .odr_q  (odr_q)
  );

  ind_gpio_padmux #(.PIN_W(PIN_W)) u_mux (
    .dir     (dir_q),
    .alt     (alt_q),
    .odr     (odr_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: rtl/ind_gpio_port_chk.sv
module ind_gpio_port_chk
  import ind_gpio_pkg::*;
#(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [PIN_W-1:0]  wdata,
  input logic [PIN_W-1:0]  rdata,
  input logic [PIN_W-1:0]  pad_in,
  input logic [PIN_W-1:0]  pad_oe,
  input logic [PIN_W-1:0]  idx_q,
  input logic [PIN_W-1:0]  dir_q,
  input logic [PIN_W-1:0]  alt_q,
  input logic [PIN_W-1:0]  in_q
);
  logic win_wr;
  assign win_wr = cs && we && (addr == ADDR_W'(OFS_WIN));

  // R1: reset leaves all pads released and read data cleared
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && rdata == '0 && dir_q == '1 && alt_q == '0));

  // R3: window write with direction index lands in the direction bits
  a_r3_dir_write: assert property (@(posedge clk) disable iff (rst)
    (win_wr && idx_q == PIN_W'(IDX_DIR)) |=> dir_q == $past(wdata));

  // R5: window write with an unmapped index leaves both sub-registers alone
  a_r5_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (win_wr && idx_q != PIN_W'(IDX_DIR) && idx_q != PIN_W'(IDX_ALT))
      |=> ($stable(dir_q) && $stable(alt_q)));

  // R10: read data holds when no read strobe is present
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(cs && !we) |=> $stable(rdata));

  if (SYNC_STAGES == 2) begin : g_lat
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
      if (rst)                   since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    // R9: input register trails the pads by three edges
    a_r9_input_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> in_q == $past(pad_in, 3));
  end
endmodule

bind ind_gpio_port ind_gpio_port_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs     (cs),
  .we     (we),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .pad_in (pad_in),
  .pad_oe (pad_oe),
  .idx_q  (idx_q),
  .dir_q  (dir_q),
  .alt_q  (alt_q),
  .in_q   (in_q)
);

// File: tb/ind_gpio_port_test.sv
`timescale 1ns/100ps
module ind_gpio_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;
  logic [7:0] alt_out = 8'h00;
  logic [7:0] alt_oe = 8'h00;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ind_gpio_port uut (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    cs = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pad_oe after reset", pad_oe, 8'h00);
    chk("R1 rdata after reset", rdata, 8'h00);
    rd(2'd1, v); chk("R1 window reads 00 after reset", v, 8'h00);
    rd(2'd3, v); chk("R1 output latch reset", v, 8'h00);
    rd(2'd0, v); chk("R1 selector reset", v, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd1, v); chk("R1 direction reset all inputs", v, 8'hFF);
    wr(2'd0, 8'h02);
    rd(2'd1, v); chk("R1 alternate reset", v, 8'h00);
  endtask

  task automatic t_offsets;
    logic [7:0] v;
    wr(2'd0, 8'hA7);
    rd(2'd0, v); chk("R2 selector readback", v, 8'hA7);
    wr(2'd3, 8'h3C);
    rd(2'd3, v); chk("R2 output latch readback", v, 8'h3C);
  endtask

  task automatic t_subregs;
    logic [7:0] v;
    wr(2'd0, 8'h01); wr(2'd1, 8'h5A);
    wr(2'd0, 8'h02); wr(2'd1, 8'hC3);
    wr(2'd0, 8'h01);
    rd(2'd1, v); chk("R3 direction readback", v, 8'h5A);
    wr(2'd0, 8'h02);
    rd(2'd1, v); chk("R4 alternate readback", v, 8'hC3);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(2'd0, 8'h03); wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R5 index 03 reads 00", v, 8'h00);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R5 index 00 reads 00", v, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h81);
    rd(2'd1, v); chk("R5 index FF reads 00", v, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd1, v); chk("R5 direction untouched", v, 8'h5A);
    wr(2'd0, 8'h02);
    rd(2'd1, v); chk("R5 alternate untouched", v, 8'hC3);
  endtask

  task automatic t_drive;
    wr(2'd0, 8'h02); wr(2'd1, 8'h00);
    wr(2'd0, 8'h01); wr(2'd1, 8'h0F);
    wr(2'd3, 8'h96);
    chk("R6 pad_oe for output pins", pad_oe, 8'hF0);
    chk("R6 pad_out follows latch", pad_out, 8'h96);
    wr(2'd1, 8'hFF);
    chk("R7 all inputs released", pad_oe, 8'h00);
    wr(2'd1, 8'h00);
    chk("R6 all outputs driven", pad_oe, 8'hFF);
  endtask

  task automatic t_alt;
    wr(2'd3, 8'hF0);
    wr(2'd0, 8'h01); wr(2'd1, 8'hFF);
    wr(2'd0, 8'h02); wr(2'd1, 8'h0F);
    alt_oe = 8'h05; alt_out = 8'h03;
    #0.5;
    chk("R8 alt oe with inputs", pad_oe, 8'h05);
    chk("R8 alt out value", pad_out, 8'hF3);
    wr(2'd0, 8'h01); wr(2'd1, 8'h00);
    chk("R8 alt oe with outputs", pad_oe, 8'hF5);
    alt_oe = 8'hFA; alt_out = 8'h0C;
    #0.5;
    chk("R8 alt inputs follow live", pad_oe, 8'hFA);
    chk("R8 alt out follows live", pad_out, 8'hFC);
    wr(2'd1, 8'hFF); wr(2'd0, 8'h02); wr(2'd1, 8'h00);
  endtask

  task automatic t_input;
    logic [7:0] v;
    pad_in = 8'h11;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R9 settled input", v, 8'h11);
    pad_in = 8'hA5;
    rd(2'd2, v); chk("R9 first edge old", v, 8'h11);
    rd(2'd2, v); chk("R9 second edge old", v, 8'h11);
    rd(2'd2, v); chk("R9 third edge old", v, 8'h11);
    rd(2'd2, v); chk("R9 fourth edge new", v, 8'hA5);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 write to input ignored", v, 8'hA5);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    wr(2'd3, 8'h44);
    rd(2'd3, v); chk("R10 read loads", v, 8'h44);
    wr(2'd3, 8'h99);
    chk("R10 held across write", rdata, 8'h44);
    addr = 2'd0;
    @(negedge clk);
    chk("R10 held while idle", rdata, 8'h44);
    rd(2'd3, v); chk("R10 next read loads", v, 8'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_offsets();
    t_subregs();
    t_unmapped();
    t_drive();
    t_alt();
    t_input();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule